// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM Core

This block is a single-port synchronous memory driven by a pipelined command protocol in which the data phase of every command falls exactly one clock after the command itself. A read and a write can therefore follow each other on consecutive edges with no idle cycle on the data bus. Each enabled edge samples a load/advance control, a read/write select, three chip enables, four active-low byte write enables and an address. The stored word is 36 bits wide and is split into four 9-bit lanes, each made of one byte plus its parity bit. The bidirectional data bus is split into a data-in port, a data-out port and an output-enable flag.

A controller state machine tracks burst state in three states: `ST_IDLE`, `ST_RD_BURST` and `ST_WR_BURST`. There are five transitions:
- **LOAD_RD**: load/advance low, chip selected, read/write high. Goes to `ST_RD_BURST`.
- **LOAD_WR**: load/advance low, chip selected, read/write low. Goes to `ST_WR_BURST`.
- **DESELECT**: load/advance low, chip not selected. Goes to `ST_IDLE`.
- **ADVANCE**: load/advance high in a burst state. Stays in that state and steps a 2-bit counter.
- **NOOP**: load/advance high in `ST_IDLE`. Stays in `ST_IDLE`.

Burst addresses are formed by XORing the counter into the two lowest bits of the loaded address. An active-low clock enable freezes the whole pipeline. A write still waiting for its data is forwarded to a read of the same word that is issued on the same edge.

Top module: `zbt_sram_core`

## Requirements
- R1: A load write (load/advance low, chip selected, read/write low) stores `din` at the external address on the next enabled edge, in the lanes whose byte enable is low.
- R2: A load read (load/advance low, chip selected, read/write high) raises `oe` and presents the addressed word on `dout` in the cycle after the command edge.
- R3: During a burst advance the read/write input is ignored. Every beat keeps the direction latched by the load cycle.
- R4: The chip is selected only when `ce1_n`=0, `ce2_n`=0 and `ce2`=1. Any single false enable deselects it.
- R5: A deselect (load/advance low, chip not selected) drives `oe` low in the cycle after that edge.
- R6: Load/advance high while no burst is active is a no-op. `oe` stays low and memory is untouched.
- R7: With `cke_n` high an edge is ignored: `dout`, `oe`, the burst state and any pending write data phase are all unchanged.
- R8: Beat n of a burst addresses the loaded address with its two low bits XORed with n mod 4 (order s, s^1, s^2, s^3, then s again). The upper address bits keep the loaded value.
- R9: Lane k is bits [9k+8:9k] and is written only when `bw_n[k]`=0. Any combination of lanes may be written, and `bw_n`=4'b1111 stores nothing. Byte enables are sampled with the command.
- R10: From reset `oe` is low, and `dout` reads zero whenever `oe` is low.
- R11: A read issued on the edge that completes a write to the same address returns the newly written lanes merged with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| adv_ld | input | 1 | 0 = load a new command, 1 = advance the burst |
| rd_wr | input | 1 | 1 = read, 0 = write (sampled on load only) |
| ce1_n | input | 1 | Active-low chip enable |
| ce2_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| bw_n | input | 4 | Active-low byte lane write enables |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data, taken one cycle after the command |
| dout | output | 36 | Read data, valid while `oe` is high |
| oe | output | 1 | Output enable for the data bus |

## Verification
Two functions can fall in the same cycle: the data phase of a write, and a new read command aimed at the same word. The bench provokes this by issuing a load read to an address right after a load write to that address, once with all lanes enabled and once with a partial lane mask. It then compares the returned word against a behavioural model in which the write is applied before the read. The bench also overlaps a clock-enable stall with a pending write data phase and with a running read burst, and checks that the stalled edge neither commits the write nor steps the burst.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int CNT_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } zbt_state_e;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  en_n
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int k = 0; k < LANES; k++) begin
            if (!en_n[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int HI_W = ADDR_W - CNT_W;

    zbt_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else if (!cke_n) begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and command outputs
    always_comb begin
        state_d   = state_q;
        base_d    = base_q;
        cnt_d     = cnt_q;
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = base_q;
        if (!adv_ld) begin
            if (sel) begin
                // LOAD_RD / LOAD_WR
                state_d   = rd_wr ? ST_RD_BURST : ST_WR_BURST;
                base_d    = addr;
                cnt_d     = '0;
                cmd_valid = 1'b1;
                cmd_write = !rd_wr;
                cmd_addr  = addr;
            end else begin
                // DESELECT
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    // NOOP
                    state_d = ST_IDLE;
                end
                ST_RD_BURST, ST_WR_BURST: begin
                    // ADVANCE
                    cnt_d     = cnt_q + 1'b1;
                    cmd_valid = 1'b1;
                    cmd_write = (state_q == ST_WR_BURST);
                    cmd_addr  = {base_q[ADDR_W-1 -: HI_W], base_q[CNT_W-1:0] ^ cnt_d};
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && state_q != ST_IDLE) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R8

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel) |=> (state_q == ST_IDLE)); // R5

    AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && adv_ld) |-> (cmd_addr[ADDR_W-1 -: HI_W] == base_q[ADDR_W-1 -: HI_W])); // R8
endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LANES-1:0]  cmd_bw_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_en
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    logic              ph_valid, ph_write;
    logic [ADDR_W-1:0] ph_addr;
    logic [LANES-1:0]  ph_bw_n;
    logic [WORD_W-1:0] wr_word, rd_src;
    logic              ph_commit, fwd_hit, rd_cmd;

    assign ph_commit = ph_valid && ph_write;
    assign wr_word   = lane_merge(mem[ph_addr], din, ph_bw_n);
    assign fwd_hit   = ph_commit && (ph_addr == cmd_addr);
    assign rd_src    = fwd_hit ? wr_word : mem[cmd_addr];
    assign rd_cmd    = cmd_valid && !cmd_write;

    always_ff @(posedge clk) begin
        if (!cke_n && ph_commit) mem[ph_addr] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_valid <= 1'b0;
            ph_write <= 1'b0;
            ph_addr  <= '0;
            ph_bw_n  <= '1;
            rd_word  <= '0;
            rd_en    <= 1'b0;
        end else if (!cke_n) begin
            ph_valid <= cmd_valid;
            ph_write <= cmd_write;
            ph_addr  <= cmd_addr;
            ph_bw_n  <= cmd_bw_n;
            rd_en    <= rd_cmd;
            if (rd_cmd) rd_word <= rd_src;
        end
    end

    AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && cmd_valid && cmd_write) |=> !rd_en); // R3
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              ce2,
    input  logic [3:0]        bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [35:0]       din,
    output logic [35:0]       dout,
    output logic              oe
);
    logic              sel;
    logic              cmd_valid, cmd_write;
    logic [ADDR_W-1:0] cmd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              rd_en;

    assign sel = !ce1_n && !ce2_n && ce2;

    zbt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .adv_ld    (adv_ld),
        .rd_wr     (rd_wr),
        .sel       (sel),
        .addr      (addr),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr)
    );

    zbt_datapath #(.ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_bw_n  (bw_n),
        .din       (din),
        .rd_word   (rd_word),
        .rd_en     (rd_en)
    );

    assign oe   = rd_en;
    assign dout = rd_en ? rd_word : '0;

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(oe))); // R7

    AST_LOAD_READ_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && sel && rd_wr) |=> oe); // R2

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel) |=> !oe); // R5

    AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (dout == '0)); // R10
endmodule

// File: tb/zbt_sram_core_bench.sv
module zbt_sram_core_bench;
    localparam logic [2:0] SEL    = 3'b001; // {ce1_n, ce2_n, ce2}
    localparam logic [2:0] DS_CE1 = 3'b101;
    localparam logic [2:0] DS_CE2N = 3'b011;
    localparam logic [2:0] DS_CE2 = 3'b000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0, adv_ld = 1'b0, rd_wr = 1'b1;
    logic        ce1_n = 1'b1, ce2_n = 1'b0, ce2 = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [5:0]  addr = '0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        oe;

    int checks = 0;
    int failures = 0;

    // behavioural model state
    logic [35:0] mm [64];
    bit          m_active = 0;
    bit          m_read = 0;
    int          m_base = 0;
    int          m_cnt = 0;
    bit          p_valid = 0, p_write = 0;
    int          p_addr = 0;
    logic [3:0]  p_bw = 4'hF;
    logic [35:0] exp_q = '0;
    bit          exp_oe = 0;

    always #2 clk = ~clk;

    zbt_sram_core #(.ADDR_W(6)) u_zbt_sram_core (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld), .rd_wr(rd_wr),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .ce2(ce2), .bw_n(bw_n), .addr(addr),
        .din(din), .dout(dout), .oe(oe)
    );

    function automatic logic [35:0] pat(input int s);
        return 36'(s) * 36'h0_2468_ACE1 + 36'hF_0F0F_0F0F;
    endfunction

    task automatic check_out(input string tag);
        logic [35:0] e;
        e = exp_oe ? exp_q : 36'h0;
        checks++;
        if (oe !== exp_oe || dout !== e) begin
            failures++;
            $display("FAIL %s: oe=%0b dout=%h expected oe=%0b dout=%h", tag, oe, dout, exp_oe, e);
        end
    endtask

    task automatic model_edge(input logic a_adv, input logic rw, input logic [2:0] ce,
                              input logic [3:0] bw, input logic [5:0] ad, input logic [35:0] d);
        bit c_valid, c_write;
        int c_addr;
        bit s;
        c_valid = 0; c_write = 0; c_addr = 0;
        s = (ce == SEL);
        if (p_valid && p_write) begin
            for (int k = 0; k < 4; k++)
                if (!p_bw[k]) mm[p_addr][k*9 +: 9] = d[k*9 +: 9];
        end
        if (!a_adv) begin
            if (s) begin
                m_active = 1; m_read = rw; m_base = int'(ad); m_cnt = 0;
                c_valid = 1; c_write = !rw; c_addr = int'(ad);
            end else begin
                m_active = 0;
            end
        end else if (m_active) begin
            m_cnt = (m_cnt + 1) % 4;
            c_valid = 1; c_write = !m_read;
            c_addr = (m_base & ~3) | ((m_base & 3) ^ m_cnt);
        end
        if (c_valid && !c_write) begin
            exp_q = mm[c_addr];
            exp_oe = 1;
        end else begin
            exp_oe = 0;
        end
        p_valid = c_valid; p_write = c_write; p_addr = c_addr; p_bw = bw;
    endtask

    task automatic step(input logic a_adv, input logic rw, input logic [2:0] ce,
                        input logic [3:0] bw, input logic [5:0] ad, input logic [35:0] d,
                        input logic ck, input string tag);
        adv_ld = a_adv; rd_wr = rw; {ce1_n, ce2_n, ce2} = ce;
        bw_n = bw; addr = ad; din = d; cke_n = ck;
        @(posedge clk);
        if (!ck) model_edge(a_adv, rw, ce, bw, ad, d);
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R10 reset state");
        rst_n = 1'b1;
        step(0, 1, DS_CE1, 4'hF, 0, 0, 0, "R10 idle after reset");

        // R1: load writes to 0..7, all lanes
        for (int i = 0; i < 8; i++)
            step(0, 0, SEL, 4'h0, 6'(i), (i == 0) ? 36'h0 : pat(i - 1), 0, "R1 load write");
        step(0, 1, DS_CE1, 4'hF, 0, pat(7), 0, "R5 deselect after writes");

        // R2: load reads back
        for (int i = 0; i < 8; i++)
            step(0, 1, SEL, 4'hF, 6'(7 - i), 0, 0, "R2 load read");
        step(0, 1, DS_CE1, 4'hF, 0, 0, 0, "R5 deselect after reads");

        // R3/R8: write burst from 38 (low bits 10), rd_wr high during advance ignored
        step(0, 0, SEL, 4'h0, 6'd38, 0, 0, "R3 write burst load");
        step(1, 1, SEL, 4'h0, 6'd0, pat(100), 0, "R3 write burst beat");
        step(1, 1, SEL, 4'h0, 6'd0, pat(101), 0, "R3 write burst beat");
        step(1, 1, SEL, 4'h0, 6'd0, pat(102), 0, "R8 write burst beat");
        step(0, 1, DS_CE2, 4'hF, 0, pat(103), 0, "R4 deselect ce2 low");

        // R3/R8: read burst from 37 with wrap, rd_wr low during advance ignored
        step(0, 1, SEL, 4'hF, 6'd37, 0, 0, "R8 read burst beat 0");
        step(1, 0, SEL, 4'hF, 6'd0, 0, 0, "R3 read burst ignores rd_wr");
        step(1, 0, SEL, 4'hF, 6'd0, 0, 0, "R8 read burst beat 2");
        step(1, 0, SEL, 4'hF, 6'd0, 0, 0, "R8 read burst beat 3");
        step(1, 0, SEL, 4'hF, 6'd0, 0, 0, "R8 read burst wrap");
        step(0, 1, DS_CE2N, 4'hF, 0, 0, 0, "R5 deselect ce2_n high");
        step(1, 1, SEL, 4'hF, 6'd5, 0, 0, "R6 advance after deselect");
        step(1, 0, SEL, 4'h0, 6'd5, pat(55), 0, "R6 advance no-op");
        step(0, 1, SEL, 4'hF, 6'd5, 0, 0, "R6 memory untouched by no-op");
        step(0, 1, DS_CE1, 4'hF, 0, 0, 0, "R4 deselect ce1_n high");

        // R9: lane enables
        step(0, 0, SEL, 4'b0000, 6'd10, 0, 0, "R9 full write");
        step(0, 0, SEL, 4'b1010, 6'd10, pat(20), 0, "R9 partial write");
        step(0, 0, SEL, 4'b1111, 6'd10, pat(21), 0, "R9 no-lane write");
        step(0, 1, SEL, 4'hF, 6'd10, pat(22), 0, "R9 read merged");
        step(0, 1, DS_CE1, 4'hF, 0, 0, 0, "R9 merged word");

        // R11: forwarding
        step(0, 0, SEL, 4'b0000, 6'd12, 0, 0, "R11 write");
        step(0, 1, SEL, 4'hF, 6'd12, pat(30), 0, "R11 read during write phase");
        step(0, 0, SEL, 4'b0110, 6'd12, 0, 0, "R11 partial write");
        step(0, 1, SEL, 4'hF, 6'd12, pat(31), 0, "R11 forwarded merge");
        step(0, 1, DS_CE1, 4'hF, 0, 0, 0, "R11 deselect");

        // R7: freeze during read burst
        step(0, 1, SEL, 4'hF, 6'd1, 0, 0, "R7 read burst load");
        step(1, 1, SEL, 4'hF, 6'd0, 0, 1, "R7 frozen advance");
        step(0, 1, DS_CE1, 4'hF, 0, 0, 1, "R7 frozen deselect");
        step(1, 1, SEL, 4'hF, 6'd0, 0, 0, "R7 resumed beat");
        step(1, 1, SEL, 4'hF, 6'd0, 0, 0, "R7 next beat");
        // R7: freeze during write data phase
        step(0, 0, SEL, 4'h0, 6'd20, 0, 0, "R7 write load");
        step(0, 1, SEL, 4'hF, 6'd20, pat(40), 1, "R7 frozen write phase");
        step(0, 1, DS_CE1, 4'hF, 0, pat(41), 0, "R7 write completes");
        step(0, 1, SEL, 4'hF, 6'd20, 0, 0, "R1 readback after stall");
        step(0, 1, DS_CE1, 4'hF, 0, 0, 0, "R7 write took later data");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule